// File: doc/BRIEF.md
# Immediate Operand Extender

This combinational unit produces the 32-bit immediate operand for a 32-bit RISC-V integer core. It takes the instruction word and a three-bit format select. From instruction bits 31 down to 7 it puts back together the immediate field of the selected encoding, which may be split across the word. It then fills the upper bits with the sign (bit 31) or, for the upper-immediate format, clears the low twelve bits. The low seven bits of the word are the opcode and never reach the result.

The decoder upstream picks the format code for each instruction. The extended value then feeds the ALU operand multiplexer, and it feeds the branch and jump target adder. The extender only gathers and extends bits. It does not decide which code an instruction needs. Codes above the last defined format yield an all-zero result.

Top module: `imm_extender`

## Requirements
- R1: With select 3'b000 the result is instruction bits [31:20] read as a 12-bit two's-complement value and sign-extended to 32 bits.
- R2: With select 3'b001 the result is the 12-bit value formed by instruction bits [31:25] as the upper seven bits and bits [11:7] as the lower five, sign-extended.
- R3: With select 3'b010 the result is the 13-bit branch offset, sign-extended. Its bit 12 is instruction bit 31, bit 11 is bit 7, bits 10:5 are bits [30:25], bits 4:1 are bits [11:8], and bit 0 is zero.
- R4: With select 3'b011 the result is the 21-bit jump offset, sign-extended. Its bit 20 is instruction bit 31, bits 19:12 are bits [19:12], bit 11 is bit 20, bits 10:1 are bits [30:21], and bit 0 is zero.
- R5: With select 3'b100 the result is instruction bits [31:12] in result bits [31:12], with result bits [11:0] zero.
- R6: Select codes 3'b101, 3'b110 and 3'b111 give a result of zero whatever the instruction word is.
- R7: Instruction bits [6:0] have no effect on the result under any select code.
- R8: For select codes 3'b000 to 3'b011, every result bit from 31 down to 20 equals instruction bit 31.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_word | input | 32 | Instruction word; only bits [31:7] are used |
| imm_sel | input | 3 | Immediate format select code |
| imm_value | output | 32 | Assembled and extended immediate |

## Verification
The sign fill and the scattered-field reassembly land on the same result in the same evaluation for the branch and jump formats. There, instruction bit 31 is both the top field bit and the source of every replicated upper bit. A one is walked through each position and a zero is walked through an all-ones word, under every select code. This exposes each bit on its own and also shows it overlapping the sign fill. Each result is compared with a value the bench computes as a signed sum of weighted bit fields. The bench also flips the opcode bits and checks that the result does not change.

// File: rtl/imm_ext_pkg.sv
// Package: shared constants and types for the immediate extender.
// Assumes a 32-bit instruction word whose immediate bits lie in [31:7].
package imm_ext_pkg;
    localparam int XLEN    = 32;
    localparam int SEL_W   = 3;
    localparam int NUM_FMT = 5;
    localparam int FLD_LO  = 7;
    localparam int FLD_W   = XLEN - FLD_LO;

    typedef enum logic [SEL_W-1:0] {
        FMT_I = 3'd0,
        FMT_S = 3'd1,
        FMT_B = 3'd2,
        FMT_J = 3'd3,
        FMT_U = 3'd4
    } imm_fmt_e;

    typedef logic [XLEN-1:0] word_t;
endpackage

// File: rtl/imm_sel_decode.sv
// Module: turns the format select code into a one-hot vector.
// Assumes codes at or above NUM_FMT are unused; they give an all-zero vector.
module imm_sel_decode
    import imm_ext_pkg::*;
#(
    parameter int N_FMT = NUM_FMT,
    parameter int SW    = SEL_W
) (
    input  logic [SW-1:0]    sel,
    output logic [N_FMT-1:0] hot
);
    // One comparator per defined format.
    for (genvar f = 0; f < N_FMT; f++) begin : g_cmp
        assign hot[f] = (sel == SW'(f));
    end
endmodule

// File: rtl/imm_format_builder.sv
// Module: builds one candidate immediate for each format from bits [31:7].
// Assumes fld[k] holds instruction bit k+FLD_LO; all formats need 32-bit words.
module imm_format_builder
    import imm_ext_pkg::*;
(
    input  logic [FLD_W-1:0]              fld,
    output logic [NUM_FMT-1:0][XLEN-1:0]  cand
);
    localparam int O = FLD_LO;

    logic sgn;
    assign sgn = fld[31-O];

    // Put the split fields back together and apply the sign fill for each layout.
    always_comb begin
        cand        = '0;
        cand[FMT_I] = {{20{sgn}}, fld[31-O:20-O]};
        cand[FMT_S] = {{20{sgn}}, fld[31-O:25-O], fld[11-O:7-O]};
        cand[FMT_B] = {{19{sgn}}, sgn, fld[7-O], fld[30-O:25-O], fld[11-O:8-O], 1'b0};
        cand[FMT_J] = {{11{sgn}}, sgn, fld[19-O:12-O], fld[20-O], fld[30-O:21-O], 1'b0};
        cand[FMT_U] = {fld[31-O:12-O], 12'b0};
    end
endmodule

// File: rtl/imm_onehot_mux.sv
// Module: AND-OR selector over the candidate immediates.
// Assumes hot has at most one bit set; an all-zero hot gives zero.
module imm_onehot_mux
    import imm_ext_pkg::*;
#(
    parameter int N_FMT = NUM_FMT,
    parameter int W     = XLEN
) (
    input  logic [N_FMT-1:0]        hot,
    input  logic [N_FMT-1:0][W-1:0] cand,
    output logic [W-1:0]            y
);
    // Gate each candidate with its select bit and OR the gated candidates.
    always_comb begin
        y = '0;
        for (int f = 0; f < N_FMT; f++) begin
            y = y | (cand[f] & {W{hot[f]}});
        end
    end
endmodule

// File: rtl/imm_extender.sv
// Module: top of the immediate extender; purely combinational, no clock or reset.
// Assumes the caller supplies a defined select code; unused codes give zero.
module imm_extender
    import imm_ext_pkg::*;
(
    input  logic [XLEN-1:0]  instr_word,
    input  logic [SEL_W-1:0] imm_sel,
    output logic [XLEN-1:0]  imm_value
);
    logic [NUM_FMT-1:0]           fmt_hot;
    logic [NUM_FMT-1:0][XLEN-1:0] fmt_cand;

    imm_sel_decode #(.N_FMT(NUM_FMT), .SW(SEL_W)) u_dec (
        .sel (imm_sel),
        .hot (fmt_hot)
    );

    imm_format_builder u_bld (
        .fld  (instr_word[XLEN-1:FLD_LO]),
        .cand (fmt_cand)
    );

    imm_onehot_mux #(.N_FMT(NUM_FMT), .W(XLEN)) u_mux (
        .hot  (fmt_hot),
        .cand (fmt_cand),
        .y    (imm_value)
    );

    // Check the decoder, the builder and the mux against each other once the inputs are known.
    always_comb begin
        if (!$isunknown(imm_sel) && !$isunknown(instr_word)) begin
            assert_sel_onehot_R6: assert ($onehot0(fmt_hot))
                else $error("decoder raised more than one format");
            if (imm_sel > 3'd4) begin
                assert_unused_zero_R6: assert (imm_value == '0)
                    else $error("unused select gave nonzero immediate");
            end
            if (imm_sel == 3'd2) begin
                assert_branch_even_R3: assert (imm_value[0] == 1'b0)
                    else $error("branch offset odd");
            end
            if (imm_sel == 3'd3) begin
                assert_jump_even_R4: assert (imm_value[0] == 1'b0)
                    else $error("jump offset odd");
            end
            if (imm_sel == 3'd4) begin
                assert_upper_low_clear_R5: assert (imm_value[11:0] == 12'h000)
                    else $error("upper immediate low bits set");
            end
            if (imm_sel <= 3'd3) begin
                assert_sign_fill_R8: assert (imm_value[31:20] == {12{instr_word[31]}})
                    else $error("sign fill mismatch");
            end
        end
    end
endmodule

// File: tb/test_imm_extender.sv
module test_imm_extender;
    logic        clk = 1'b0;
    logic [31:0] instr_word;
    logic [2:0]  imm_sel;
    logic [31:0] imm_value;
    int          n_checks = 0;
    int          n_fail   = 0;
    bit          done     = 1'b0;

    always #5 clk = ~clk;

    imm_extender i_imm_extender (
        .instr_word (instr_word),
        .imm_sel    (imm_sel),
        .imm_value  (imm_value)
    );

    // Reference model: signed sums of weighted fields.
    function automatic logic [31:0] ref_imm(input logic [31:0] w, input logic [2:0] s);
        longint v;
        case (s)
            3'd0: v = longint'(w[30:20]) - (w[31] ? 2048 : 0);
            3'd1: v = longint'(w[30:25]) * 32 + longint'(w[11:7]) - (w[31] ? 2048 : 0);
            3'd2: v = longint'(w[7]) * 2048 + longint'(w[30:25]) * 32
                      + longint'(w[11:8]) * 2 - (w[31] ? 4096 : 0);
            3'd3: v = longint'(w[19:12]) * 4096 + longint'(w[20]) * 2048
                      + longint'(w[30:21]) * 2 - (w[31] ? 1048576 : 0);
            3'd4: v = longint'(w[31:12]) * 4096;
            default: v = 0;
        endcase
        return v[31:0];
    endfunction

    function automatic string tag_of(input logic [2:0] s);
        case (s)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return "R4";
            3'd4: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s instr=%h sel=%0d actual=%h expected=%h",
                     tag, instr_word, imm_sel, act, exp);
        end
    endtask

    task automatic apply(input logic [31:0] w, input logic [2:0] s);
        @(negedge clk);
        instr_word = w;
        imm_sel    = s;
        @(posedge clk);
        #1;
    endtask

    task automatic run_one(input logic [31:0] w, input logic [2:0] s);
        apply(w, s);
        chk(tag_of(s), imm_value, ref_imm(w, s));
        if (s <= 3'd3) chk("R8", {20'h0, imm_value[31:20]}, {20'h0, {12{w[31]}}});
    endtask

    initial begin
        logic [31:0] lfsr;
        logic [31:0] held;
        instr_word = '0;
        imm_sel    = '0;
        // Idle state: zero word under the first format gives zero.
        apply(32'h0, 3'd0);
        chk("R1", imm_value, 32'h0);
        // Walking one and walking zero under every select code.
        for (int s = 0; s < 8; s++) begin
            for (int b = 0; b < 32; b++) begin
                run_one(32'h1 << b, 3'(s));
                run_one(~(32'h1 << b), 3'(s));
            end
        end
        // Pseudo-random words, plus the opcode-independence check (R7).
        lfsr = 32'hACE1_1234;
        for (int k = 0; k < 40; k++) begin
            for (int s = 0; s < 8; s++) begin
                run_one(lfsr, 3'(s));
                held = imm_value;
                apply(lfsr ^ 32'h0000_007F, 3'(s));
                chk("R7", imm_value, held);
            end
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        end
        // Boundary values: extreme negative and positive offsets.
        run_one(32'h8000_0000, 3'd2);
        run_one(32'h7FFF_FF80, 3'd3);
        run_one(32'hFFFF_FFFF, 3'd4);
        run_one(32'hFFFF_FFFF, 3'd7);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule